// File: doc/BRIEF.md
# Pipelined Vector Magnitude and Phase Unit

This block converts a signed Cartesian pair into polar form. It uses shift-and-add CORDIC micro-rotations in vectoring mode. Each micro-rotation turns the vector toward the positive x axis and adds up the angle it turned through. After the last rotation, x holds the scaled length of the vector and the angle accumulator holds its phase. A fixed multiplier removes the CORDIC gain, so the magnitude comes out true-scaled.

The unit is fully pipelined. It takes one sample per clock with no stalls. A valid flag moves along the pipeline beside the data. A vector in the left half-plane is first turned by half a turn. This lets the rotations converge, and the phase output covers the whole circle. The phase is given in degrees, as a signed value scaled by 2^16. For example, 90 degrees reads as 5898240.

Top module: `cordic_vec_pipe`

## Requirements
- R1: `out_valid` repeats `in_valid` exactly STAGES+2 clock cycles later, which is 18 cycles with the default parameters. Each sample's results appear in the same cycle as its flag. A cycle in which `in_valid` is low produces a cycle in which `out_valid` is low.
- R2: While `rst_n` is low, `out_valid`, `out_mag` and `out_ang` are all zero. Samples that are in the pipeline when reset is asserted never produce an `out_valid` pulse afterwards.
- R3: For a valid sample, `out_mag` is an unsigned integer within ±2 LSB of sqrt(x²+y²).
- R4: For a valid sample, `out_ang` is a signed value in degrees × 2^16, within ±0.01° (±655 LSB) of atan2(y, x). Its range is −180° to +180°.
- R5: Inputs with x < 0 are handled by a half-turn pre-rotation. They give correct phases in the second and third quadrants. An input on the negative x axis (y = 0) reads as +180°.
- R6: Inputs on the axes give phases near 0° for (+A, 0), +90° for (0, +A) and −90° for (0, −A). Their magnitude is A.
- R7: The input (100, 200) gives a magnitude of 224 (within 2 LSB of 223.6) and a phase of 63.43°.
- R8: Full-scale inputs, including (−32768, −32768) with a magnitude of 46341, do not overflow the datapath. They meet R3 and R4.
- R9: Samples presented on back-to-back cycles each produce their own result, in the order they were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the cycle's input pair as a sample |
| in_x | input | IN_W (16) | Signed x coordinate |
| in_y | input | IN_W (16) | Signed y coordinate |
| out_valid | output | 1 | Marks the cycle's outputs as a result |
| out_mag | output | IN_W (16) | Unsigned vector length, rounded |
| out_ang | output | DW (32) | Signed phase in degrees × 2^16 |

## Verification
On every cycle, the assertions check the following:
- the valid flag is handed from stage to stage, from the input to the output register;
- the outputs are cleared while reset is held;
- a valid result never exceeds the bounds on magnitude and phase that rule out overflow.

Numeric accuracy can only be shown by the bench's scenarios, which compare each result with a real-number model. These cover the quadrants, the axis and left half-plane cases, full scale, the reference vector, back-to-back ordering, and the flushing of samples caught by a reset.

// File: rtl/cordic_vec_pipe.sv
module cordic_vec_pipe #(
  parameter int IN_W   = 16,
  parameter int DW     = 32,
  parameter int STAGES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [IN_W-1:0] in_x,
  input  logic signed [IN_W-1:0] in_y,
  output logic                 out_valid,
  output logic        [IN_W-1:0] out_mag,
  output logic signed [DW-1:0] out_ang
);

  localparam int FRAC = DW - IN_W - 2;
  localparam int SH   = 16 + FRAC;
  localparam int PW   = DW + 18;
  localparam int GAIN = 39797;
  localparam logic signed [DW-1:0] HALF_TURN = DW'(180 * 65536);

  function automatic logic signed [DW-1:0] atan_deg(input int i);
    case (i)
      0:  atan_deg = DW'(2949120);
      1:  atan_deg = DW'(1740967);
      2:  atan_deg = DW'(919879);
      3:  atan_deg = DW'(466945);
      4:  atan_deg = DW'(234379);
      5:  atan_deg = DW'(117304);
      6:  atan_deg = DW'(58666);
      7:  atan_deg = DW'(29335);
      8:  atan_deg = DW'(14668);
      9:  atan_deg = DW'(7334);
      10: atan_deg = DW'(3667);
      11: atan_deg = DW'(1833);
      12: atan_deg = DW'(917);
      13: atan_deg = DW'(458);
      14: atan_deg = DW'(229);
      15: atan_deg = DW'(115);
      default: atan_deg = '0;
    endcase
  endfunction

  logic signed [DW-1:0] x_q [STAGES+1];
  logic signed [DW-1:0] y_q [STAGES+1];
  logic signed [DW-1:0] z_q [STAGES+1];
  logic        [STAGES:0] v_q;

  logic signed [DW-1:0] x_ext, y_ext;
  logic                 left_half;
  assign x_ext     = DW'(in_x) <<< FRAC;
  assign y_ext     = DW'(in_y) <<< FRAC;
  assign left_half = in_x[IN_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q[0] <= '0;
      y_q[0] <= '0;
      z_q[0] <= '0;
    end else if (left_half) begin
      x_q[0] <= -x_ext;
      y_q[0] <= -y_ext;
      z_q[0] <= in_y[IN_W-1] ? -HALF_TURN : HALF_TURN;
    end else begin
      x_q[0] <= x_ext;
      y_q[0] <= y_ext;
      z_q[0] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[STAGES-1:0], in_valid};
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic signed [DW-1:0] x_sh, y_sh;
    assign x_sh = x_q[i] >>> i;
    assign y_sh = y_q[i] >>> i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_q[i+1] <= '0;
        y_q[i+1] <= '0;
        z_q[i+1] <= '0;
      end else if (!y_q[i][DW-1]) begin
        x_q[i+1] <= x_q[i] + y_sh;
        y_q[i+1] <= y_q[i] - x_sh;
        z_q[i+1] <= z_q[i] + atan_deg(i);
      end else begin
        x_q[i+1] <= x_q[i] - y_sh;
        y_q[i+1] <= y_q[i] + x_sh;
        z_q[i+1] <= z_q[i] - atan_deg(i);
      end
    end
  end

  logic signed [PW-1:0] prod, prod_rnd;
  assign prod     = PW'(x_q[STAGES]) * PW'(GAIN);
  assign prod_rnd = prod + (PW'(1) <<< (SH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_ang   <= '0;
    end else begin
      out_valid <= v_q[STAGES];
      out_mag   <= IN_W'(prod_rnd >>> SH);
      out_ang   <= z_q[STAGES];
    end
  end

endmodule

// File: rtl/cordic_vec_pipe_chk.sv
module cordic_vec_pipe_chk #(
  parameter int IN_W   = 16,
  parameter int DW     = 32,
  parameter int STAGES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [STAGES:0]        stage_v,
  input logic                   out_valid,
  input logic [IN_W-1:0]        out_mag,
  input logic signed [DW-1:0]   out_ang
);

  localparam int MAG_MAX = (1 << (IN_W - 1)) * 3 / 2;
  localparam int ANG_MAX = 180 * 65536 + 655;

  // R1: valid enters the chain one cycle after the port
  p_valid_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stage_v[0] == $past(in_valid));

  // R1: valid advances one stage per cycle
  p_valid_chain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stage_v[STAGES:1] == $past(stage_v[STAGES-1:0]));

  // R1: output flag follows the last stage by one cycle
  p_valid_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(stage_v[STAGES]));

  // R3, R8: magnitude bounded, no wrap
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_mag) <= MAG_MAX);

  // R4: phase inside the half-turn range plus tolerance
  p_ang_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_ang) <= ANG_MAX && int'(out_ang) >= -ANG_MAX));

  // R2: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r2: assert (out_valid == 1'b0 && out_mag == '0 && out_ang == '0);
    end
  end

endmodule

bind cordic_vec_pipe cordic_vec_pipe_chk #(
  .IN_W(IN_W), .DW(DW), .STAGES(STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stage_v(v_q),
  .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
);

// File: tb/cordic_vec_pipe_tb_top.sv
`timescale 1ns/1ps
module cordic_vec_pipe_tb_top;
  localparam int IN_W = 16;
  localparam int DW   = 32;
  localparam int LAT  = 18;
  localparam real PI  = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_x = '0;
  logic signed [IN_W-1:0] in_y = '0;
  logic out_valid;
  logic [IN_W-1:0] out_mag;
  logic signed [DW-1:0] out_ang;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int bx [64];
  int by [64];
  bit bv [64];

  always #4 clk = ~clk;

  cordic_vec_pipe #(.IN_W(IN_W), .DW(DW), .STAGES(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_mag(out_mag), .out_ang(out_ang)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  task automatic run_batch(input int n, input string req);
    for (int c = 0; c <= n + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT && c - LAT < n) begin
        int k;
        real em, ea, am, aa;
        k = c - LAT;
        chk(out_valid == bv[k], "R1", "out_valid", real'(out_valid), real'(bv[k]));
        if (bv[k]) begin
          em = $sqrt(real'(bx[k]) * bx[k] + real'(by[k]) * by[k]);
          ea = $atan2(real'(by[k]), real'(bx[k])) * 180.0 / PI * 65536.0;
          am = real'(out_mag);
          aa = real'(int'(out_ang));
          chk((am - em) <= 2.0 && (em - am) <= 2.0, {req, " R3"}, "magnitude", am, em);
          chk((aa - ea) <= 655.0 && (ea - aa) <= 655.0, {req, " R4"}, "angle", aa, ea);
        end
      end
      if (c < n) begin
        in_valid = bv[c];
        in_x = IN_W'(bx[c]);
        in_y = IN_W'(by[c]);
      end else begin
        in_valid = 1'b0;
        in_x = '0;
        in_y = '0;
      end
    end
  endtask

  task automatic put(input int k, input int x, input int y, input bit v);
    bx[k] = x; by[k] = y; bv[k] = v;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "out_valid in reset", real'(out_valid), 0.0);
    chk(out_mag == '0, "R2", "out_mag in reset", real'(out_mag), 0.0);
    chk(out_ang == '0, "R2", "out_ang in reset", real'(int'(out_ang)), 0.0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reference;
    put(0, 100, 200, 1);
    run_batch(1, "R7");
  endtask

  task automatic t_quadrants;
    put(0, 3000, 4000, 1);
    put(1, -3000, 4000, 1);
    put(2, -3000, -4000, 1);
    put(3, 3000, -4000, 1);
    put(4, 5, 12, 1);
    run_batch(5, "R5");
  endtask

  task automatic t_axes;
    put(0, 20000, 0, 1);
    put(1, 0, 20000, 1);
    put(2, 0, -20000, 1);
    put(3, -20000, 0, 1);
    put(4, 1, 0, 1);
    run_batch(5, "R6 R5");
  endtask

  task automatic t_fullscale;
    put(0, -32768, -32768, 1);
    put(1, 32767, 32767, 1);
    put(2, -32768, 32767, 1);
    put(3, 32767, -32768, 1);
    put(4, -32768, 1, 1);
    run_batch(5, "R8");
  endtask

  task automatic t_stream;
    for (int k = 0; k < 24; k++)
      put(k, (k * 2731) % 60001 - 30000, (k * 7919) % 50001 - 25000, 1);
    run_batch(24, "R9");
  endtask

  task automatic t_bubbles;
    put(0, 1000, 7000, 1);
    put(1, 999, 999, 0);
    put(2, -8000, 300, 1);
    put(3, 4000, -900, 1);
    put(4, -5, -5, 0);
    put(5, 0, 0, 0);
    put(6, -123, -4567, 1);
    run_batch(7, "R1");
  endtask

  task automatic t_flush;
    int seen;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_x = IN_W'(1000 + k); in_y = IN_W'(500);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "out_valid during mid-run reset", real'(out_valid), 0.0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < LAT + 4; c++) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    chk(seen == 0, "R2", "flushed samples reappearing", real'(seen), 0.0);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    #20 rst_n = 1'b1;
    t_reset();
    t_reference();
    t_quadrants();
    t_axes();
    t_fullscale();
    t_stream();
    t_bubbles();
    t_flush();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule